// File: doc/BRIEF.md
# Buffered Edge-Compare PWM Generator

This block produces one pulse-width-modulated output from a signed up-counter. The counter starts at a programmable start value, counts upward one step per prescaled tick, and on reaching a programmable end value it returns to the start value. Two compare values place the output's rising and falling edges anywhere in the count span. Setting the rising-edge value equal to the start value gives edge-aligned pulses. Placing both edges symmetrically about the span's midpoint gives centered pulses. Any other placement gives an asymmetric waveform.

A simple write port fills shadow copies of the four values. The shadow values become active only when a load-okay flag is set and a reload point arrives. A reload point can be the end of the count span, its midpoint, or both. A divider lets only every Nth reload point perform the transfer. The load-okay flag clears itself when the transfer happens, so a host can poll it.

Top module: `pwm_edge_gen`

## Requirements
- R1: After reset the count output is 0, the PWM output is low and the load-okay flag is low.
- R2: Count values are two's-complement. While running, the count steps up by one per tick from the start value to the end value. On the tick after the end value it returns to the start value.
- R3: When the count equals the rising-edge value, the output goes high one clock later. When the count equals the falling-edge value, the output goes low one clock later. The high time per span is (fall − rise) ticks.
- R4: If the rising-edge and falling-edge values are equal, the output stays low.
- R5: With the rising edge equal to the start value, changing only the falling-edge value changes the pulse width.
- R6: A write with wr_sel 0, 1, 2 or 3 goes to the shadow start, end, rise or fall value. Such a write has no effect on the output until load-okay is set and a transfer happens.
- R7: When rl_full is set, a count equal to the end value on a tick is a reload point. When rl_half is set, a count equal to floor((start+end)/2) on a tick is a reload point. A transfer at the end point starts the next span from the new start value.
- R8: With rl_div = N−1, the transfer happens at the Nth reload point after load-okay is set.
- R9: A ldok_set pulse sets load-okay. Load-okay clears on the clock of the transfer.
- R10: With prescale value P, the count advances once every P+1 clocks.
- R11: While run is low, the count holds the start value and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter run enable |
| presc | input | PW | Prescale value P (divide by P+1) |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 2 | Shadow select: 0 start, 1 end, 2 rise, 3 fall |
| wr_data | input | W | Signed write data |
| ldok_set | input | 1 | Sets the load-okay flag |
| rl_full | input | 1 | Enables the end-of-span reload point |
| rl_half | input | 1 | Enables the midpoint reload point |
| rl_div | input | FW | Reload divider, N−1 |
| ldok | output | 1 | Load-okay flag, cleared by the transfer |
| cnt_out | output | W | Current count (two's-complement) |
| pwm_out | output | 1 | PWM output |

## Verification
An active value that is corrupted or loaded too early shows up within one count span. It appears as a wrong high-time total at pwm_out or a wrong wrap value at cnt_out. Reload gating faults show up in how many clocks ldok stays set after a request, and in the count value seen on the clock when ldok clears. A prescaler or run-hold fault shows up in how often cnt_out changes over a window of a few dozen clocks.

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int W  = 16,
  parameter int PW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] presc,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          ldok_set,
  input  logic          rl_full,
  input  logic          rl_half,
  input  logic [FW-1:0] rl_div,
  output logic          ldok,
  output logic [W-1:0]  cnt_out,
  output logic          pwm_out
);

  logic signed [W-1:0] cnt, init_a, mod_a, on_a, off_a;
  logic signed [W-1:0] init_s, mod_s, on_s, off_s;
  logic signed [W:0]   span_sum;
  logic [W-1:0]        half_pt;
  logic [PW-1:0]       pcnt;
  logic [FW-1:0]       rl_cnt;
  logic                tick, at_end, opp, xfer, pwm_q;

  assign tick     = run && (pcnt >= presc);
  assign span_sum = init_a + mod_a;
  assign half_pt  = span_sum[W:1];
  assign at_end   = (cnt == mod_a);
  assign opp      = tick && ((rl_full && at_end) || (rl_half && (cnt == half_pt)));
  assign xfer     = opp && ldok && (rl_cnt == rl_div);
  assign cnt_out  = cnt;
  assign pwm_out  = pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_s <= '0; mod_s <= '0; on_s <= '0; off_s <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: init_s <= wr_data;
        2'd1: mod_s  <= wr_data;
        2'd2: on_s   <= wr_data;
        default: off_s <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_a <= '0; mod_a <= '0; on_a <= '0; off_a <= '0;
    end else if (xfer) begin
      init_a <= init_s; mod_a <= mod_s; on_a <= on_s; off_a <= off_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ldok <= 1'b0;
    else if (ldok_set) ldok <= 1'b1;
    else if (xfer)     ldok <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rl_cnt <= '0;
    else if (!ldok) rl_cnt <= '0;
    else if (opp)   rl_cnt <= xfer ? '0 : rl_cnt + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt <= '0;
    else if (!run || tick)     pcnt <= '0;
    else                       pcnt <= pcnt + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= init_a;
    else if (tick)   cnt <= at_end ? (xfer ? init_s : init_a) : cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pwm_q <= 1'b0;
    else if (!run)            pwm_q <= 1'b0;
    else if (cnt == off_a)    pwm_q <= 1'b0;
    else if (cnt == on_a)     pwm_q <= 1'b1;
  end

  a_r2_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && at_end) |=> (cnt == init_a));

  a_r4_fall_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == off_a) |=> !pwm_out);

  a_r6_no_load_without_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !ldok |=> ($stable(mod_a) && $stable(off_a) && $stable(on_a)));

  a_r9_ok_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ldok_set) |=> !ldok);

  a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pwm_out && cnt == init_a));

endmodule

// File: tb/pwm_edge_gen_tb.sv
module pwm_edge_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [7:0]  presc = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        ldok_set = 1'b0;
  logic        rl_full = 1'b1;
  logic        rl_half = 1'b0;
  logic [3:0]  rl_div = '0;
  logic        ldok;
  logic [15:0] cnt_out;
  logic        pwm_out;
  int n_run = 0;
  int n_fail = 0;

  pwm_edge_gen u_dut (.clk(clk), .rst_n(rst_n), .run(run), .presc(presc),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ldok_set(ldok_set),
    .rl_full(rl_full), .rl_half(rl_half), .rl_div(rl_div),
    .ldok(ldok), .cnt_out(cnt_out), .pwm_out(pwm_out));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int val);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = 16'(val);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic req_load(output int clocks);
    @(negedge clk); ldok_set = 1'b1;
    @(negedge clk); ldok_set = 1'b0;
    clocks = 1;
    while (ldok && clocks < 300) begin
      @(negedge clk); clocks++;
    end
  endtask

  task automatic high_time(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (pwm_out) highs++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cnt_out == 16'd0 && !pwm_out && !ldok, "R1 reset state", int'(cnt_out), 0);
  endtask

  task automatic t_first_load;
    int c, h, mn, mx;
    wr(0, -4); wr(1, 3); wr(2, -4); wr(3, 0);
    run = 1'b1;
    req_load(c);
    chk(!ldok, "R9 load-okay self clear", int'(ldok), 0);
    repeat (8) @(negedge clk);
    high_time(80, h);
    chk(h == 40, "R3 high time rise=-4 fall=0", h, 40);
    mn = 100; mx = -100;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (int'($signed(cnt_out)) < mn) mn = int'($signed(cnt_out));
      if (int'($signed(cnt_out)) > mx) mx = int'($signed(cnt_out));
    end
    chk(mn == -4, "R2 signed minimum", mn, -4);
    chk(mx == 3, "R2 maximum", mx, 3);
  endtask

  task automatic t_edge_aligned;
    int c, h;
    wr(3, 2);
    req_load(c);
    repeat (8) @(negedge clk);
    high_time(80, h);
    chk(h == 60, "R5 edge-aligned width from fall value only", h, 60);
  endtask

  task automatic t_shadow_only;
    int h;
    wr(3, -2);
    repeat (16) @(negedge clk);
    high_time(80, h);
    chk(h == 60, "R6 shadow write without load-okay", h, 60);
  endtask

  task automatic t_centered;
    int c, h;
    wr(2, -2); wr(3, 2);
    req_load(c);
    repeat (8) @(negedge clk);
    high_time(80, h);
    chk(h == 40, "R3 centered pulse", h, 40);
  endtask

  task automatic t_zero_width;
    int c, h;
    wr(2, 1); wr(3, 1);
    req_load(c);
    repeat (8) @(negedge clk);
    high_time(80, h);
    chk(h == 0, "R4 equal edges stay low", h, 0);
  endtask

  task automatic t_prescale;
    int changes;
    logic [15:0] prev;
    presc = 8'd1;
    repeat (4) @(negedge clk);
    prev = cnt_out; changes = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (cnt_out != prev) changes++;
      prev = cnt_out;
    end
    chk(changes == 16, "R10 advance every two clocks", changes, 16);
    presc = 8'd0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_run_low;
    bit ok = 1'b1;
    wr(2, -4); wr(3, 3);
    run = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cnt_out != 16'hFFFC || pwm_out) ok = 1'b0;
    end
    chk(ok, "R11 hold start value while stopped", int'($signed(cnt_out)), -4);
    run = 1'b1;
    repeat (2) @(negedge clk);
    chk(cnt_out != 16'hFFFC, "R11 count resumes", int'($signed(cnt_out)), -3);
  endtask

  task automatic t_divider;
    int c;
    rl_div = 4'd2;
    req_load(c);
    chk(c >= 17 && c <= 24, "R8 third reload point", c, 20);
    rl_div = 4'd0;
    req_load(c);
    chk(c >= 1 && c <= 8, "R8 first reload point", c, 4);
  endtask

  task automatic t_half_point;
    int c;
    rl_full = 1'b0; rl_half = 1'b1;
    req_load(c);
    chk(cnt_out == 16'd0, "R7 midpoint reload", int'($signed(cnt_out)), 0);
    rl_full = 1'b1; rl_half = 1'b0;
    req_load(c);
    chk(cnt_out == 16'hFFFC, "R7 end reload", int'($signed(cnt_out)), -4);
  endtask

  initial begin
    #(20ns * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_load();
    t_edge_aligned();
    t_shadow_only();
    t_centered();
    t_zero_width();
    t_prescale();
    t_run_low();
    t_divider();
    t_half_point();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule